// File: doc/BRIEF.md
# Word-Addressed Memory and Port Router

This block sits between a small 16-bit processor core and everything that core can address. Each cycle the core presents one word address with a read enable, a write enable and write data. The block decodes the address into one of six targets: the program store (held outside the block), a stack RAM, a data RAM, a decimal-output port, a character-output port, or a keyboard-input port. The two RAMs are inside the block as synchronous single-port arrays.

The program store lives at the bottom half of the space, the stack window and the data window follow it, and three single-word ports sit directly above the data window. Every read returns its word one cycle after the request, through a multiplexer steered by the target registered on the request cycle. Port activity appears as one-cycle strobes registered on the same edge, so a printer or a key FIFO outside the block sees exactly one pulse per access.

Top module: `memmap_router`

## Requirements
- R1: A read below 32768 whose address is also below ROM_WORDS raises rom_en in the request cycle with rom_addr equal to the low 15 address bits, and rdata in the next cycle equals rom_rdata. A program-region read at or above ROM_WORDS leaves rom_en low and returns zero.
- R2: Addresses 32768 to 40959 reach the stack RAM at word index (address - 32768) modulo STACK_DEPTH; a written word reads back unchanged.
- R3: Addresses 40960 to 57343 reach the data RAM at word index (address - 40960) modulo DATA_DEPTH; a written word reads back unchanged.
- R4: A write to 57344 raises num_stb for one cycle in the next cycle, with num_data holding the full 16-bit write value.
- R5: A write to 57345 raises chr_stb for one cycle in the next cycle, with chr_data holding the low 8 bits of the write value.
- R6: A read of 57346 raises key_rd for exactly one cycle in the next cycle, and rdata in that cycle is key_data zero-extended to 16 bits.
- R7: Reads of the two output ports or of any address at or above 57347 return zero. Writes to the program region, to the key port or to addresses above 57346 change no RAM word and raise no strobe.
- R8: Every read returns its data exactly one cycle after the request, and rdata is zero in any cycle that follows a cycle without a read. A read and a write to the same RAM word in one cycle return the old word, and the new word is stored.
- R9: The synchronous active-high reset forces num_stb, chr_stb and key_rd low on the next edge, even when a port access is requested in the reset cycle. It does not alter either RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Word address from the core |
| wdata | input | 16 | Write data |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| rdata | output | 16 | Read data, one cycle after the request |
| rom_en | output | 1 | Program store read enable |
| rom_addr | output | 15 | Program store word address |
| rom_rdata | input | 16 | Program store word, valid the cycle after rom_en |
| num_stb | output | 1 | Decimal-output write pulse |
| num_data | output | 16 | Value for the decimal-output port |
| chr_stb | output | 1 | Character-output write pulse |
| chr_data | output | 8 | Character for the character-output port |
| key_rd | output | 1 | Key-read pulse, pops one key entry |
| key_data | input | 8 | Character at the head of the key queue |

## Verification
A read and a write can land on the same RAM word in one cycle, and the bench drives exactly that on a stack word that already holds a known value. It judges the rdata of the next cycle against the old value and then reads the word again to find the new value stored. A port access and a reset can also coincide: a decimal-port write is issued while reset is high, and the bench requires that no strobe follows.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned ROM_AW     = 15;
    localparam int unsigned CHAR_W     = 8;

    localparam logic [WORD_W-1:0] STACK_BASE = 16'h8000;
    localparam logic [WORD_W-1:0] DATA_BASE  = 16'hA000;
    localparam logic [WORD_W-1:0] PORT_BASE  = 16'hE000;
    localparam logic [WORD_W-1:0] NUM_PORT   = PORT_BASE;
    localparam logic [WORD_W-1:0] CHR_PORT   = PORT_BASE + 16'd1;
    localparam logic [WORD_W-1:0] KEY_PORT   = PORT_BASE + 16'd2;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PROG,
        TGT_STACK,
        TGT_DATA,
        TGT_NUM,
        TGT_CHR,
        TGT_KEY
    } target_e;

    typedef struct packed {
        target_e           tgt;
        logic              rd;
        logic              wr;
    } access_t;

    function automatic target_e decode_target(
        input logic [WORD_W-1:0] a,
        input int unsigned       rom_words
    );
        target_e t;
        if (a < STACK_BASE) begin
            t = (32'(a) < rom_words) ? TGT_PROG : TGT_NONE;
        end else if (a < DATA_BASE) begin
            t = TGT_STACK;
        end else if (a < PORT_BASE) begin
            t = TGT_DATA;
        end else if (a == NUM_PORT) begin
            t = TGT_NUM;
        end else if (a == CHR_PORT) begin
            t = TGT_CHR;
        end else if (a == KEY_PORT) begin
            t = TGT_KEY;
        end else begin
            t = TGT_NONE;
        end
        return t;
    endfunction

endpackage

// File: rtl/mm_sync_ram.sv
module mm_sync_ram #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned WIDTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_q;

    // Read-first: the output register takes the word before any write.
    always_ff @(posedge clk) begin
        if (en) begin
            rd_q <= mem[idx];
            if (we) begin
                mem[idx] <= wdata;
            end
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/mm_out_ports.sv
module mm_out_ports
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              num_hit,
    input  logic              chr_hit,
    input  logic              key_hit,
    input  logic [WORD_W-1:0] wdata,
    output logic              num_stb,
    output logic [WORD_W-1:0] num_data,
    output logic              chr_stb,
    output logic [CHAR_W-1:0] chr_data,
    output logic              key_rd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            num_stb  <= 1'b0;
            chr_stb  <= 1'b0;
            key_rd   <= 1'b0;
            num_data <= '0;
            chr_data <= '0;
        end else begin
            num_stb <= num_hit;
            chr_stb <= chr_hit;
            key_rd  <= key_hit;
            if (num_hit) begin
                num_data <= wdata;
            end
            if (chr_hit) begin
                chr_data <= wdata[CHAR_W-1:0];
            end
        end
    end

    p_num_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        num_stb |-> $past(num_hit));
    p_chr_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        chr_stb |-> ($past(chr_hit) && chr_data == $past(wdata[CHAR_W-1:0])));
    p_key_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        key_rd |-> $past(key_hit));
    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!num_stb && !chr_stb && !key_rd));

endmodule

// File: rtl/memmap_router.sv
module memmap_router
    import memmap_pkg::*;
#(
    parameter int unsigned ROM_WORDS   = 4096,
    parameter int unsigned STACK_DEPTH = 1024,
    parameter int unsigned DATA_DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       addr,
    input  logic [15:0]       wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [15:0]       rdata,
    output logic              rom_en,
    output logic [14:0]       rom_addr,
    input  logic [15:0]       rom_rdata,
    output logic              num_stb,
    output logic [15:0]       num_data,
    output logic              chr_stb,
    output logic [7:0]        chr_data,
    output logic              key_rd,
    input  logic [7:0]        key_data
);

    localparam int unsigned SAW = $clog2(STACK_DEPTH);
    localparam int unsigned DAW = $clog2(DATA_DEPTH);

    access_t             acc;
    target_e             rd_tgt_q;
    logic [WORD_W-1:0]   stack_off;
    logic [WORD_W-1:0]   data_off;
    logic [WORD_W-1:0]   stack_q;
    logic [WORD_W-1:0]   data_q;
    logic                stack_en;
    logic                data_en;

    always_comb begin
        acc.tgt = decode_target(addr, ROM_WORDS);
        acc.rd  = rd_en;
        acc.wr  = wr_en;
    end

    assign stack_off = addr - STACK_BASE;
    assign data_off  = addr - DATA_BASE;
    assign stack_en  = (acc.tgt == TGT_STACK) && (acc.rd || acc.wr);
    assign data_en   = (acc.tgt == TGT_DATA)  && (acc.rd || acc.wr);

    assign rom_en    = acc.rd && (acc.tgt == TGT_PROG);
    assign rom_addr  = addr[ROM_AW-1:0];

    mm_sync_ram #(.DEPTH(STACK_DEPTH), .WIDTH(WORD_W)) u_stack_ram (
        .clk   (clk),
        .en    (stack_en),
        .we    (acc.wr),
        .idx   (stack_off[SAW-1:0]),
        .wdata (wdata),
        .rdata (stack_q)
    );

    mm_sync_ram #(.DEPTH(DATA_DEPTH), .WIDTH(WORD_W)) u_data_ram (
        .clk   (clk),
        .en    (data_en),
        .we    (acc.wr),
        .idx   (data_off[DAW-1:0]),
        .wdata (wdata),
        .rdata (data_q)
    );

    mm_out_ports u_ports (
        .clk      (clk),
        .rst      (rst),
        .num_hit  (acc.wr && acc.tgt == TGT_NUM),
        .chr_hit  (acc.wr && acc.tgt == TGT_CHR),
        .key_hit  (acc.rd && acc.tgt == TGT_KEY),
        .wdata    (wdata),
        .num_stb  (num_stb),
        .num_data (num_data),
        .chr_stb  (chr_stb),
        .chr_data (chr_data),
        .key_rd   (key_rd)
    );

    // Target of the read issued last cycle steers the return mux.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_tgt_q <= TGT_NONE;
        end else begin
            rd_tgt_q <= acc.rd ? acc.tgt : TGT_NONE;
        end
    end

    always_comb begin
        unique case (rd_tgt_q)
            TGT_PROG:  rdata = rom_rdata;
            TGT_STACK: rdata = stack_q;
            TGT_DATA:  rdata = data_q;
            TGT_KEY:   rdata = {{(WORD_W-CHAR_W){1'b0}}, key_data};
            default:   rdata = '0;
        endcase
    end

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(addr) > KEY_PORT) |-> (rdata == '0));
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> (rdata == '0));
    p_rom_high_r1: assert property (@(posedge clk) disable iff (rst)
        (addr < STACK_BASE && 32'(addr) >= ROM_WORDS) |-> !rom_en);

endmodule

// File: tb/test_memmap_router.sv
module test_memmap_router;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] exp_rd;
        logic [2:0]  exp_stb;   // {num, chr, key}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 16'h8000, 16'h1111, 16'h0000, 3'b000, 4'd2},  // R2 write
        '{1'b0, 1'b1, 16'h83FF, 16'h2222, 16'h0000, 3'b000, 4'd2},  // R2 top of depth
        '{1'b0, 1'b1, 16'hA000, 16'h3333, 16'h0000, 3'b000, 4'd3},  // R3 write
        '{1'b0, 1'b1, 16'hA7FF, 16'h4444, 16'h0000, 3'b000, 4'd3},  // R3 top of depth
        '{1'b1, 1'b0, 16'h8000, 16'h0000, 16'h1111, 3'b000, 4'd2},  // R2 read
        '{1'b1, 1'b0, 16'h83FF, 16'h0000, 16'h2222, 3'b000, 4'd2},
        '{1'b1, 1'b0, 16'hA000, 16'h0000, 16'h3333, 3'b000, 4'd3},  // R3 read
        '{1'b1, 1'b0, 16'hA7FF, 16'h0000, 16'h4444, 3'b000, 4'd3},
        '{1'b1, 1'b0, 16'h0010, 16'h0000, 16'h5A4A, 3'b000, 4'd1},  // R1 rom word
        '{1'b1, 1'b0, 16'h0FFF, 16'h0000, 16'h55A5, 3'b000, 4'd1},  // R1 last rom word
        '{1'b1, 1'b0, 16'h1000, 16'h0000, 16'h0000, 3'b000, 4'd1},  // R1 beyond rom
        '{1'b1, 1'b0, 16'h7FFF, 16'h0000, 16'h0000, 3'b000, 4'd1},
        '{1'b0, 1'b1, 16'hE000, 16'h1234, 16'h0000, 3'b100, 4'd4},  // R4
        '{1'b0, 1'b1, 16'hE001, 16'hBEEF, 16'h0000, 3'b010, 4'd5},  // R5
        '{1'b1, 1'b0, 16'hE002, 16'h0000, 16'h0041, 3'b001, 4'd6},  // R6
        '{1'b1, 1'b0, 16'hE003, 16'h0000, 16'h0000, 3'b000, 4'd7},  // R7 unmapped
        '{1'b1, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 3'b000, 4'd7},
        '{1'b1, 1'b0, 16'hE000, 16'h0000, 16'h0000, 3'b000, 4'd7},  // R7 out port read
        '{1'b0, 1'b1, 16'hE002, 16'h5555, 16'h0000, 3'b000, 4'd7},  // R7 key port write
        '{1'b0, 1'b1, 16'hF000, 16'h5555, 16'h0000, 3'b000, 4'd7},
        '{1'b1, 1'b1, 16'h8000, 16'h7777, 16'h1111, 3'b000, 4'd8},  // R8 read-first
        '{1'b1, 1'b0, 16'h8000, 16'h0000, 16'h7777, 3'b000, 4'd8},
        '{1'b0, 1'b1, 16'h8400, 16'h5555, 16'h0000, 3'b000, 4'd2},  // R2 alias to 0
        '{1'b1, 1'b0, 16'h8000, 16'h0000, 16'h5555, 3'b000, 4'd2},
        '{1'b1, 1'b0, 16'h9FFF, 16'h0000, 16'h2222, 3'b000, 4'd2},  // R2 window end
        '{1'b1, 1'b0, 16'hDFFF, 16'h0000, 16'h4444, 3'b000, 4'd3},  // R3 window end
        '{1'b0, 1'b0, 16'h8000, 16'h0000, 16'h0000, 3'b000, 4'd8}   // R8 idle
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr, wdata, rdata, rom_rdata, num_data;
    logic        rd_en, wr_en, rom_en, num_stb, chr_stb, key_rd;
    logic [14:0] rom_addr;
    logic [7:0]  chr_data, key_data;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Program store model: word = address XOR 16'h5A5A, one cycle latency.
    always_ff @(posedge clk) begin
        rom_rdata <= rom_en ? ({1'b0, rom_addr} ^ 16'h5A5A) : 16'hDEAD;
    end

    memmap_router i_memmap_router (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd_en(rd_en),
        .wr_en(wr_en), .rdata(rdata), .rom_en(rom_en), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata), .num_stb(num_stb), .num_data(num_data),
        .chr_stb(chr_stb), .chr_data(chr_data), .key_rd(key_rd),
        .key_data(key_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic w, input logic [15:0] a,
                         input logic [15:0] d);
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; wdata = d;
    endtask

    task automatic settle;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        key_data = 8'h41;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check({num_stb, chr_stb, key_rd} == 3'b000, "R9", "strobes in reset",
              {13'd0, num_stb, chr_stb, key_rd}, 16'h0);
        check(rdata == 16'h0, "R8", "rdata in reset", rdata, 16'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            drive(VECS[i].rd, VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            settle();
            check(rdata == VECS[i].exp_rd, tag, $sformatf("rdata v%0d", i),
                  rdata, VECS[i].exp_rd);
            check({num_stb, chr_stb, key_rd} == VECS[i].exp_stb, tag,
                  $sformatf("strobes v%0d", i),
                  {13'd0, num_stb, chr_stb, key_rd}, {13'd0, VECS[i].exp_stb});
            if (VECS[i].exp_stb[2])
                check(num_data == VECS[i].wdata, "R4", "num_data", num_data,
                      VECS[i].wdata);
            if (VECS[i].exp_stb[1])
                check(chr_data == VECS[i].wdata[7:0], "R5", "chr_data",
                      {8'd0, chr_data}, {8'd0, VECS[i].wdata[7:0]});
        end

        // R1 rom_en and rom_addr in the request cycle
        drive(1'b1, 1'b0, 16'h0123, 16'h0);
        #1;
        check(rom_en && rom_addr == 15'h0123, "R1", "rom_en/addr",
              {rom_en, rom_addr}, 16'h8123);
        drive(1'b0, 1'b1, 16'h0123, 16'h9999);
        #1;
        check(!rom_en, "R7", "rom_en on prog write", {15'd0, rom_en}, 16'h0);

        // R6 single pulse per read, back-to-back reads give two pulses
        drive(1'b1, 1'b0, 16'hE002, 16'h0);
        settle();
        check(key_rd, "R6", "key pulse 1", {15'd0, key_rd}, 16'h1);
        settle();
        check(key_rd, "R6", "key pulse 2", {15'd0, key_rd}, 16'h1);
        drive(1'b0, 1'b0, 16'h0, 16'h0);
        settle();
        check(!key_rd, "R6", "key pulse end", {15'd0, key_rd}, 16'h0);

        // R9 port write during reset yields no strobe; RAM survives reset
        drive(1'b0, 1'b1, 16'hE000, 16'hAAAA);
        rst = 1'b1;
        settle();
        check(!num_stb, "R9", "num_stb after reset write", {15'd0, num_stb}, 16'h0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 1'b0, 16'hA000, 16'h0);
        settle();
        check(rdata == 16'h3333, "R9", "data RAM kept over reset", rdata, 16'h3333);
        drive(1'b1, 1'b0, 16'h8000, 16'h0);
        settle();
        check(rdata == 16'h5555, "R9", "stack RAM kept over reset", rdata, 16'h5555);

        drive(1'b0, 1'b0, 16'h0, 16'h0);
        settle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule